// File: doc/BRIEF.md
# External Interrupt Request Controller

This block is the pin-side front end for sixteen external interrupt lines of a microcontroller. Each pin is brought into the clock domain through two flops. The synchronised value is then tested against a detection condition chosen per channel: high level, low level, rising edge or falling edge. When the condition is met, a sticky cause bit is set. The cause bit stays set until software removes it. A channel's request line to the interrupt controller is its cause bit ANDed with its enable bit.

Software uses a small register bus with four word addresses. Address 0 holds the per-channel enable, address 1 returns the cause flags, address 2 is the clear port, and address 3 holds the two-bit detection selectors. Reads are combinational from `addr_i` while `sel_i` is high. Writes take effect at the clock edge where `sel_i` and `wr_i` are both high. A level-detected cause stays set after the pin returns to its inactive level. The usual service sequence is to read the cause register and then clear the serviced bits.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The channels work independently. A detection on one channel sets only that channel's cause bit (cause register, address 1, bit n for channel n).
- R2: Each channel's detection condition is bits [2n+1:2n] of the mode register at address 3: 00 low level, 01 high level, 10 rising edge, 11 falling edge. An edge mode ignores the opposite edge.
- R3: A pin change applied between two clock edges shows in the cause register after the third following rising clock edge, and not after the second. This covers the two synchroniser flops plus the cause flop.
- R4: Request output `irq_o[n]` is high exactly when cause bit n and enable bit n (address 0) are both set. Changing the enable does not alter the cause.
- R5: With a level mode selected, the cause bit stays set after the pin returns to its inactive level.
- R6: Writing address 2 clears each cause bit whose write-data bit is 0. Bits written as 1 keep their cause. Reading address 2 returns 0.
- R7: When a detection and a clear of the same channel fall on the same clock edge, the cause stays set. A clear issued while a level condition is still present therefore does not remove the cause.
- R8: Writes to the cause register at address 1 have no effect.
- R9: Rewriting a channel's mode while its pin is steady never sets a cause by itself.
- R10: While reset is asserted, enable, cause, mode and all request outputs are 0. The synchroniser flops reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NCH | Asynchronous external interrupt pins |
| sel_i | input | 1 | Register bus select |
| wr_i | input | 1 | Write strobe (with sel_i) |
| addr_i | input | 2 | Word address: 0 enable, 1 cause, 2 clear, 3 mode |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, zero-extended |
| irq_o | output | NCH | Request lines to the interrupt controller |

## Verification
The bench samples the cause register one cycle before and exactly at the three-edge latency. A design with one synchroniser stage too few or too many would fail that check. It times a clear write to land on the same edge as a fresh rising-edge detection, and it issues a clear while a level condition is still held. A design that gives the clear priority would lose the cause in both cases. It switches a channel from a level mode to an edge mode with the pin held high, which catches a design whose edge history restarts from a reset value and reports a false edge. It also writes all ones and all zeros to the cause address, which exposes a cause register that accepts writes.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           sel_i,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  localparam int MW = 2 * NCH;

  logic [NCH-1:0] s1_q, s2_q, prev_q, en_q, cause_q, det, clr_mask;
  logic [MW-1:0]  mode_q;
  logic           wr_en, wr_clr, wr_mode;

  assign wr_en   = sel_i & wr_i & (addr_i == 2'd0);
  assign wr_clr  = sel_i & wr_i & (addr_i == 2'd2);
  assign wr_mode = sel_i & wr_i & (addr_i == 2'd3);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (mode_q[2*i +: 2])
        2'b00:   det[i] = ~s2_q[i];
        2'b01:   det[i] =  s2_q[i];
        2'b10:   det[i] =  s2_q[i] & ~prev_q[i];
        default: det[i] = ~s2_q[i] &  prev_q[i];
      endcase
    end
  end

  assign clr_mask = wr_clr ? ~wdata_i[NCH-1:0] : '0;
  assign irq_o    = cause_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= '1;
      s2_q    <= '1;
      prev_q  <= '1;
      en_q    <= '0;
      cause_q <= '0;
      mode_q  <= '0;
    end else begin
      s1_q    <= pin_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      cause_q <= (cause_q & ~clr_mask) | det;
      if (wr_en)   en_q   <= wdata_i[NCH-1:0];
      if (wr_mode) mode_q <= wdata_i[MW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        2'd0:    rdata_o[NCH-1:0] = en_q;
        2'd1:    rdata_o[NCH-1:0] = cause_q;
        2'd3:    rdata_o[MW-1:0]  = mode_q;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel_i,
  input logic           wr_i,
  input logic [1:0]     addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] cause_q,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] s2_q,
  input logic [NCH-1:0] prev_q,
  input logic [2*NCH-1:0] mode_q
);
  logic clr_wr;
  assign clr_wr = sel_i & wr_i & (addr_i == 2'd2);

  a_r5_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  a_r6_clear_only_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (($past(cause_q) & ~cause_q & $past(wdata_i[NCH-1:0])) == '0));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~en_q) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r2_rise_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b10 && s2_q[i] && !prev_q[i]) |=> cause_q[i]);
    a_r2_fall_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b11 && !s2_q[i] && prev_q[i]) |=> cause_q[i]);
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .en_q(en_q), .cause_q(cause_q), .irq_o(irq_o),
  .s2_q(s2_q), .prev_q(prev_q), .mode_q(mode_q)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  localparam int NCH = 16;
  localparam int DW  = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] pin_i;
  logic sel_i = 0, wr_i = 0;
  logic [1:0] addr_i = 0;
  logic [DW-1:0] wdata_i = 0;
  logic [DW-1:0] rdata_o;
  logic [NCH-1:0] irq_o;
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] v;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    sel_i = 0; wr_i = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    sel_i = 1; wr_i = 0; addr_i = a;
    #1 d = rdata_o;
    sel_i = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    pin_i = '1; pin_i[2] = 1'b0;
    cyc(2);
    rd(2'd0, v); chk("R10 enable in reset", v, 0);
    rd(2'd1, v); chk("R10 cause in reset", v, 0);
    rd(2'd3, v); chk("R10 mode in reset", v, 0);
    chk("R10 irq in reset", irq_o, 0);
    rst_n = 1;
    // ch0 low-level -> later rising, ch1 falling, ch2 high, ch3 low, rest low
    wr(2'd3, 32'h0000_001C);
    cyc(3);
    wr(2'd2, 32'h0);
    cyc(1);
    rd(2'd1, v); chk("R6 clear all", v, 0);
  endtask

  task automatic t_mode_change;
    wr(2'd3, 32'h0000_001E);
    cyc(4);
    rd(2'd1, v); chk("R9 mode change with steady pin", v, 0);
  endtask

  task automatic t_rise_latency;
    pin_i[0] = 0; cyc(5);
    rd(2'd1, v); chk("R2 rising mode ignores fall", v[0], 0);
    pin_i[0] = 1; cyc(2);
    rd(2'd1, v); chk("R3 not set after two edges", v[0], 0);
    cyc(1);
    rd(2'd1, v); chk("R3 set after three edges", v[0], 1);
    chk("R4 irq off while disabled", irq_o[0], 0);
    wr(2'd0, 32'h1);
    chk("R4 irq on when enabled", irq_o, 16'h0001);
    wr(2'd0, 32'h0);
    rd(2'd1, v); chk("R4 disable keeps cause", v[0], 1);
    wr(2'd0, 32'h1);
  endtask

  task automatic t_fall_and_clear;
    pin_i[1] = 0; cyc(3);
    rd(2'd1, v); chk("R2 falling sets ch1", v[1:0], 2'b11);
    pin_i[1] = 1;
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd1, v); chk("R6 zero bit clears, one bits keep", v[1:0], 2'b10);
    chk("R4 irq drops with cause", irq_o[0], 0);
    rd(2'd2, v); chk("R6 clear reads zero", v, 0);
    wr(2'd2, 32'hFFFF_FFFD);
    rd(2'd1, v); chk("R6 ch1 cleared", v, 0);
  endtask

  task automatic t_level;
    pin_i[2] = 1; cyc(4);
    wr(2'd2, 32'hFFFF_FFFB);
    rd(2'd1, v); chk("R7 clear loses to held level", v[2], 1);
    pin_i[2] = 0; cyc(4);
    rd(2'd1, v); chk("R5 level cause held after release", v[2], 1);
    wr(2'd2, 32'hFFFF_FFFB);
    rd(2'd1, v); chk("R5 level cause cleared after release", v[2], 0);
  endtask

  task automatic t_same_cycle;
    pin_i[0] = 0; cyc(4);
    pin_i[0] = 1;
    @(posedge clk); @(posedge clk); #1;
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd1, v); chk("R7 edge and clear same edge", v[0], 1);
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd1, v); chk("R7 later clear works", v[0], 0);
  endtask

  task automatic t_cause_write;
    pin_i[0] = 0; cyc(4); pin_i[0] = 1; cyc(3);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R8 cause write zeros ignored", v, 1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R8 cause write ones ignored", v, 1);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_multi;
    pin_i[15:4] = ~12'hA5C;
    cyc(3);
    rd(2'd1, v); chk("R1 independent channels", v, 32'h0000_A5C0);
    pin_i[15:4] = '1;
    cyc(3);
    wr(2'd2, 32'h0);
    rd(2'd1, v); chk("R1 all cleared", v, 0);
  endtask

  initial begin
    t_reset;
    t_mode_change;
    t_rise_latency;
    t_fall_and_clear;
    t_level;
    t_same_cycle;
    t_cause_write;
    t_multi;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule